// File: doc/BRIEF.md
# Banked GPIO Expander Register File

This block is the register file of a 40-pin general-purpose I/O expander. The pins are split into six ports of uneven width. Ports 2 and 5 hold four pins each, and the other four ports hold eight pins each. A simple byte-wide register bus reaches the registers. A serial target elsewhere in the chip would translate its transactions onto this bus. The block produces per-pin output values, output enables and drive-mode selects, and it samples the pin input levels.

Each port has its input level and its output value at fixed, directly addressed locations. A port-select register sets which port the configuration registers act on. Those banked registers are the event mask, PWM routing, direction and the three drive modes. Software writes the port number first, then accesses the banked registers.

A PWM generator outside the block supplies one waveform bit per pin. A pin that is routed to PWM and configured as an output drives that waveform instead of its output-register bit.

Top module: `gpx_regfile`

## Requirements
- R1: After reset, every pin is an input (pin_oe = 0), every output register and every PWM-routing bit is 0, every pin is in pull-up mode, every event-mask bit is 1, the port select is 0 and bus_rdata is 0x00.
- R2: A read of address 0x00+N (N = 0..5) returns the input levels of port N, with bit k taken from pin base(N)+k. The port bases are 0, 8, 16, 20, 28 and 36.
- R3: Address 0x08+N reads and writes the output register of port N. On a pin that is not PWM-driven, pin_out equals the pin's output-register bit.
- R4: Address 0x18 holds a 3-bit port select that reads back zero-extended. Addresses 0x19 (event mask), 0x1A (PWM routing), 0x1C (direction), 0x1D (pull-up), 0x21 (strong) and 0x23 (high-impedance) act only on the selected port, and the other ports are left unchanged.
- R5: In the direction register, a 1 makes the pin an input (pin_oe = 0) and a 0 makes it an output (pin_oe = 1).
- R6: Writing a 1 to a pin's bit in one drive-mode register selects that mode and clears the pin's bit in the other two mode registers. Writing 0 bits has no effect. Each pin always has exactly one mode, reported on pin_pullup, pin_strong or pin_hiz.
- R7: When a pin's PWM-routing bit is 1 and its direction bit is 0, pin_out follows pwm_wave for that pin. When the pin is an input, pin_out follows the output register.
- R8: On the four-pin ports (2 and 5), register bits 7:4 read 0 and writes to them are ignored.
- R9: A read of address 0x2E returns 0x4 in bits 7:4 and the REV_ID parameter in bits 3:0.
- R10: bus_rdata is registered. It shows the addressed value in the clock after bus_rd and holds its value while bus_rd is low. Unmapped addresses read 0x00.
- R11: With the port select at 6 or 7, writes to the banked registers change no port, and reads of them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 40 | Sampled pin input levels |
| pwm_wave | input | 40 | Per-pin PWM waveform |
| pin_out | output | 40 | Pad output value |
| pin_oe | output | 40 | Pad output enable |
| pin_pullup | output | 40 | Pull-up mode selected |
| pin_strong | output | 40 | Strong-drive mode selected |
| pin_hiz | output | 40 | High-impedance mode selected |
| pin_evmask | output | 40 | Per-pin event mask bits |

## Verification
The assertions take for granted that a read or a write is a single-cycle strobe with a stable address, and that the port select is not rewritten in the same cycle as a banked access it is meant to steer. The stimulus raises each strobe for exactly one cycle and never asserts read and write together. Every banked access is placed at least one cycle after the port-select write that steers it. The stimulus steps through the select values 0, 1, 2 and 5 and the out-of-range value 6, so that each claim of R4 and R11 is exercised at the pins.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int NUM_PORTS = 6;
    localparam int NUM_PINS  = 40;
    localparam int AW        = 8;
    localparam int DW        = 8;
    localparam int SEL_W     = $clog2(NUM_PORTS);

    localparam logic [AW-1:0] A_IN_BASE  = 8'h00;
    localparam logic [AW-1:0] A_OUT_BASE = 8'h08;
    localparam logic [AW-1:0] A_PSEL     = 8'h18;
    localparam logic [AW-1:0] A_EVMASK   = 8'h19;
    localparam logic [AW-1:0] A_PWMRT    = 8'h1A;
    localparam logic [AW-1:0] A_DIR      = 8'h1C;
    localparam logic [AW-1:0] A_PULLUP   = 8'h1D;
    localparam logic [AW-1:0] A_STRONG   = 8'h21;
    localparam logic [AW-1:0] A_HIZ      = 8'h23;
    localparam logic [AW-1:0] A_IDENT    = 8'h2E;

    localparam logic [3:0] FAMILY_NIB = 4'h4;

    // first pin of each port; one past the last port gives the pin count
    function automatic int port_base(input int p);
        case (p)
            0:       return 0;
            1:       return 8;
            2:       return 16;
            3:       return 20;
            4:       return 28;
            5:       return 36;
            default: return NUM_PINS;
        endcase
    endfunction

    function automatic int port_width(input int p);
        return port_base(p + 1) - port_base(p);
    endfunction
endpackage

// File: rtl/gpx_port_bank.sv
module gpx_port_bank
    import gpx_pkg::*;
#(
    parameter int PORT_IDX = 0,
    parameter int W        = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [W-1:0]     wbits,
    input  logic [SEL_W-1:0] sel,
    input  logic [W-1:0]     pin_in,
    input  logic [W-1:0]     pwm_in,
    output logic [DW-1:0]    rd_byte,
    output logic [W-1:0]     pad_out,
    output logic [W-1:0]     pad_oe,
    output logic [W-1:0]     pu_q,
    output logic [W-1:0]     st_q,
    output logic [W-1:0]     hz_q,
    output logic [W-1:0]     mask_q
);
    localparam logic [AW-1:0]    A_MY_IN  = A_IN_BASE + AW'(PORT_IDX);
    localparam logic [AW-1:0]    A_MY_OUT = A_OUT_BASE + AW'(PORT_IDX);
    localparam logic [SEL_W-1:0] MY_SEL   = SEL_W'(PORT_IDX);

    logic [W-1:0] out_q, dir_q, route_q;
    logic         picked;

    assign picked = (sel == MY_SEL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q   <= '0;
            dir_q   <= '1;
            route_q <= '0;
            mask_q  <= '1;
            pu_q    <= '1;
            st_q    <= '0;
            hz_q    <= '0;
        end else if (wr_en) begin
            if (addr == A_MY_OUT) out_q <= wbits;
            if (picked) begin
                case (addr)
                    A_EVMASK: mask_q  <= wbits;
                    A_PWMRT:  route_q <= wbits;
                    A_DIR:    dir_q   <= wbits;
                    A_PULLUP: begin
                        pu_q <= pu_q | wbits;
                        st_q <= st_q & ~wbits;
                        hz_q <= hz_q & ~wbits;
                    end
                    A_STRONG: begin
                        pu_q <= pu_q & ~wbits;
                        st_q <= st_q | wbits;
                        hz_q <= hz_q & ~wbits;
                    end
                    A_HIZ: begin
                        pu_q <= pu_q & ~wbits;
                        st_q <= st_q & ~wbits;
                        hz_q <= hz_q | wbits;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_byte = '0;
        if (addr == A_MY_IN)  rd_byte = DW'(pin_in);
        if (addr == A_MY_OUT) rd_byte = DW'(out_q);
        if (picked) begin
            case (addr)
                A_EVMASK: rd_byte = DW'(mask_q);
                A_PWMRT:  rd_byte = DW'(route_q);
                A_DIR:    rd_byte = DW'(dir_q);
                A_PULLUP: rd_byte = DW'(pu_q);
                A_STRONG: rd_byte = DW'(st_q);
                A_HIZ:    rd_byte = DW'(hz_q);
                default:  ;
            endcase
        end
    end

    assign pad_oe  = ~dir_q;
    assign pad_out = (route_q & ~dir_q & pwm_in) | (~(route_q & ~dir_q) & out_q);

    // R6: every pin holds exactly one drive mode
    for (genvar b = 0; b < W; b++) begin : g_mode_chk
        assert_one_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $countones({pu_q[b], st_q[b], hz_q[b]}) == 1);
    end

    // R4: a direction write to the selected port lands in the pad enables
    assert_dir_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && picked && addr == A_DIR |=> pad_oe == ~$past(wbits));

    // R11: a banked write aimed elsewhere leaves this port's enables alone
    assert_unsel_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !picked && addr == A_DIR |=> $stable(pad_oe));
endmodule

// File: rtl/gpx_read_port.sv
module gpx_read_port
    import gpx_pkg::*;
#(
    parameter int         NB     = NUM_PORTS,
    parameter logic [3:0] REV_ID = 4'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [SEL_W-1:0] sel,
    input  logic [NB*DW-1:0] bank_rd,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] nxt;

    always_comb begin
        nxt = '0;
        for (int p = 0; p < NB; p++) nxt = nxt | bank_rd[p*DW +: DW];
        if (addr == A_PSEL)  nxt = DW'(sel);
        if (addr == A_IDENT) nxt = {FAMILY_NIB, REV_ID};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= nxt;
    end

    // R10: read data holds between strobes
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R9: identity read carries the family nibble
    assert_ident_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr == A_IDENT |=> rdata[7:4] == FAMILY_NIB);

    // R4: the select reads back zero-extended
    assert_psel_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr == A_PSEL |=> rdata == DW'($past(sel)));
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
    import gpx_pkg::*;
#(
    parameter logic [3:0] REV_ID = 4'h0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [DW-1:0]       bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] pwm_wave,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_pullup,
    output logic [NUM_PINS-1:0] pin_strong,
    output logic [NUM_PINS-1:0] pin_hiz,
    output logic [NUM_PINS-1:0] pin_evmask
);
    localparam logic [AW-1:0] A_NARROW_OUT = A_OUT_BASE + AW'(2);

    logic [SEL_W-1:0]          sel_q;
    logic [NUM_PORTS*DW-1:0]   bank_rd;

    always_ff @(posedge clk) begin
        if (!rst_n)                              sel_q <= '0;
        else if (bus_wr && bus_addr == A_PSEL)   sel_q <= bus_wdata[SEL_W-1:0];
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        localparam int BASE = port_base(g);
        localparam int WID  = port_width(g);

        gpx_port_bank #(
            .PORT_IDX (g),
            .W        (WID)
        ) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_wr),
            .addr    (bus_addr),
            .wbits   (bus_wdata[WID-1:0]),
            .sel     (sel_q),
            .pin_in  (pin_in[BASE +: WID]),
            .pwm_in  (pwm_wave[BASE +: WID]),
            .rd_byte (bank_rd[g*DW +: DW]),
            .pad_out (pin_out[BASE +: WID]),
            .pad_oe  (pin_oe[BASE +: WID]),
            .pu_q    (pin_pullup[BASE +: WID]),
            .st_q    (pin_strong[BASE +: WID]),
            .hz_q    (pin_hiz[BASE +: WID]),
            .mask_q  (pin_evmask[BASE +: WID])
        );
    end

    gpx_read_port #(
        .NB     (NUM_PORTS),
        .REV_ID (REV_ID)
    ) rdport_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (bus_rd),
        .addr    (bus_addr),
        .sel     (sel_q),
        .bank_rd (bank_rd),
        .rdata   (bus_rdata)
    );

    // R8: the four-pin output register never shows upper bits
    assert_narrow_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == A_NARROW_OUT |=> bus_rdata[7:4] == 4'h0);
endmodule

// File: tb/gpx_regfile_tb_top.sv
module gpx_regfile_tb_top;
    typedef struct packed {
        logic       rd;
        logic [7:0] a;
        logic [7:0] d;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 42;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h00, 8'h10, 4'd2},   // R2 port 0 inputs
        '{1'b1, 8'h01, 8'h32, 4'd2},   // R2
        '{1'b1, 8'h02, 8'h04, 4'd2},   // R2 narrow port
        '{1'b1, 8'h03, 8'h65, 4'd2},   // R2
        '{1'b1, 8'h04, 8'h87, 4'd2},   // R2
        '{1'b1, 8'h05, 8'h09, 4'd2},   // R2
        '{1'b1, 8'h06, 8'h00, 4'd10},  // R10 unmapped
        '{1'b1, 8'h2E, 8'h40, 4'd9},   // R9 identity
        '{1'b1, 8'h18, 8'h00, 4'd1},   // R1 select
        '{1'b1, 8'h1C, 8'hFF, 4'd1},   // R1 direction
        '{1'b1, 8'h19, 8'hFF, 4'd1},   // R1 mask
        '{1'b1, 8'h1A, 8'h00, 4'd1},   // R1 routing
        '{1'b1, 8'h1D, 8'hFF, 4'd1},   // R1 pull-up
        '{1'b1, 8'h21, 8'h00, 4'd1},   // R1 strong
        '{1'b0, 8'h0A, 8'hFF, 4'd8},   // R8 write narrow out
        '{1'b1, 8'h0A, 8'h0F, 4'd8},   // R8
        '{1'b0, 8'h08, 8'h5A, 4'd3},   // R3
        '{1'b1, 8'h08, 8'h5A, 4'd3},   // R3
        '{1'b0, 8'h18, 8'h02, 4'd4},   // R4
        '{1'b1, 8'h18, 8'h02, 4'd4},   // R4
        '{1'b1, 8'h1C, 8'h0F, 4'd8},   // R8 banked narrow
        '{1'b1, 8'h1D, 8'h0F, 4'd8},   // R8
        '{1'b0, 8'h18, 8'h00, 4'd4},   // R4
        '{1'b0, 8'h1C, 8'hF0, 4'd5},   // R5
        '{1'b1, 8'h1C, 8'hF0, 4'd5},   // R5
        '{1'b0, 8'h21, 8'h03, 4'd6},   // R6
        '{1'b1, 8'h21, 8'h03, 4'd6},   // R6
        '{1'b1, 8'h1D, 8'hFC, 4'd6},   // R6
        '{1'b0, 8'h23, 8'h01, 4'd6},   // R6
        '{1'b1, 8'h23, 8'h01, 4'd6},   // R6
        '{1'b1, 8'h21, 8'h02, 4'd6},   // R6
        '{1'b0, 8'h1D, 8'h00, 4'd6},   // R6 zero write
        '{1'b1, 8'h1D, 8'hFC, 4'd6},   // R6
        '{1'b0, 8'h18, 8'h01, 4'd4},   // R4
        '{1'b1, 8'h1C, 8'hFF, 4'd4},   // R4 other port untouched
        '{1'b0, 8'h18, 8'h06, 4'd11},  // R11
        '{1'b0, 8'h1C, 8'h00, 4'd11},  // R11
        '{1'b1, 8'h1C, 8'h00, 4'd11},  // R11
        '{1'b1, 8'h18, 8'h06, 4'd11},  // R11
        '{1'b0, 8'h18, 8'h01, 4'd11},  // R11
        '{1'b1, 8'h1C, 8'hFF, 4'd11},  // R11 ignored write
        '{1'b1, 8'h19, 8'hFF, 4'd4}    // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [39:0] pin_in = 40'h98_7654_3210;
    logic [39:0] pwm_wave = '1;
    logic [39:0] pin_out, pin_oe, pin_pullup, pin_strong, pin_hiz, pin_evmask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpx_regfile dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .pin_in     (pin_in),
        .pwm_wave   (pwm_wave),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .pin_pullup (pin_pullup),
        .pin_strong (pin_strong),
        .pin_hiz    (pin_hiz),
        .pin_evmask (pin_evmask)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the pins
        check("R1 pin_oe", pin_oe, 40'h0);
        check("R1 pin_out", pin_out, 40'h0);
        check("R1 pin_pullup", pin_pullup, {40{1'b1}});
        check("R1 pin_strong", pin_strong | pin_hiz, 40'h0);
        check("R1 pin_evmask", pin_evmask, {40{1'b1}});
        check("R1 bus_rdata", bus_rdata, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) begin
                bus_read(VECS[i].a, rv);
                check($sformatf("R%0d vector %0d addr 0x%0h", VECS[i].req, i, VECS[i].a), rv, VECS[i].d);
            end else begin
                bus_write(VECS[i].a, VECS[i].d);
            end
        end

        // R5 port 0 pins 0..3 are outputs, 4..7 inputs
        check("R5 pin_oe port0", pin_oe[7:0], 8'h0F);
        // R3 output register drives unrouted pins
        check("R3 pin_out port0", pin_out[7:0], 8'h5A);
        // R6 modes at the pins
        check("R6 pin_hiz port0", pin_hiz[7:0], 8'h01);
        check("R6 pin_strong port0", pin_strong[7:0], 8'h02);
        check("R6 pin_pullup port0", pin_pullup[7:0], 8'hFC);

        // R7 PWM routing on outputs only
        bus_write(8'h18, 8'h00);
        bus_write(8'h1A, 8'hFF);
        @(negedge clk);
        check("R7 pwm high", pin_out[7:0], 8'h5F);
        pwm_wave = '0;
        @(negedge clk);
        check("R7 pwm low", pin_out[7:0], 8'h50);
        bus_read(8'h1A, rv);
        check("R7 routing readback", rv, 8'hFF);

        // R10 hold while idle
        repeat (3) @(negedge clk);
        check("R10 hold", bus_rdata, 8'hFF);

        // R10 one-cycle latency
        @(negedge clk);
        bus_addr = 8'h2E; bus_rd = 1'b1;
        check("R10 before edge", bus_rdata, 8'hFF);
        @(posedge clk);
        #1;
        check("R10 after edge", bus_rdata, 8'h40);
        @(negedge clk);
        bus_rd = 1'b0;

        // R8 narrow port 5 direction
        bus_write(8'h18, 8'h05);
        bus_write(8'h1C, 8'h00);
        @(negedge clk);
        check("R8 port5 pin_oe", pin_oe[39:36], 4'hF);
        check("R8 port4 untouched", pin_oe[35:28], 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule